// File: doc/BRIEF.md
# Streaming Rank-Counter Median Unit

The unit takes the N samples of one filter window as a stream, one sample per valid cycle, and returns their median. Each sample is stored together with a rank counter. When a new sample arrives it is compared against every sample already held for the window, and all of those comparisons are made in the same cycle. Each older sample that is larger than the newcomer has its rank raised by one. The newcomer is given a starting rank equal to its arrival position, minus the number of older samples that are larger than it.

Once the last sample of the window has been taken in, the ranks form a permutation of 0 to N-1. The unit then presents the stored sample whose rank is the middle value (N-1)/2, together with a one-cycle valid pulse. A start marker on the input restarts the window. Windows may follow each other with no idle cycle between them. The surrounding pipeline is expected to form the windows and handle image borders.

Top module: `rank_median_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and stays 0 until a full window has been received.
- R2: A sample accepted at position i of its window (the first sample is position 0) receives the rank i minus the number of earlier samples in the window that are strictly greater than it. A later sample equal to an earlier one therefore ranks above it.
- R3: When a new sample is strictly less than an earlier stored sample, the rank of that earlier sample rises by one; otherwise the earlier sample's rank is unchanged.
- R4: After N samples, the ranks are distinct and cover 0 to N-1. Exactly one stored sample holds the middle rank (N-1)/2. For example, with the stream 20, 42, 31, 16, 75, 50, 10, 90, 31 and N = 9, the median is 31.
- R5: `out_median` equals the middle element of the window's samples sorted in ascending order.
- R6: `out_valid` is high for exactly one cycle, in the cycle after the N-th sample of a window is accepted.
- R7: A sample accepted with `in_first` = 1 becomes position 0 of a new window. Any partly received window is discarded.
- R8: After N samples, the next accepted sample starts a new window even without `in_first`. Windows may arrive back to back, with no idle cycle between them.
- R9: Cycles with `in_valid` = 0 have no effect, whatever is on `in_data`. Gaps may occur inside a window.
- R10: Windows containing repeated values, including a window in which every value is the same, give the sorted-middle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` and `in_first` |
| in_first | input | 1 | Marks the first sample of a window |
| in_data | input | DATA_W | Sample value, unsigned |
| out_valid | output | 1 | One-cycle pulse: `out_median` holds a result |
| out_median | output | DATA_W | Median of the last complete window |

## Verification
The bench builds two copies of the unit side by side: one with a 9-sample window and one with a 25-sample window. Both use 8-bit samples. The 9-sample copy covers the directed orderings: ascending, descending, the mixed example, all-equal values, restart after a partial window, gaps inside a window and wrap without the start marker. The 25-sample copy gives five-bit ranks and long comparison rows. For both sizes, random windows drawn from a narrow value range force many ties.

// File: rtl/rmu_pkg.sv
// Package: shared helpers for the rank-counter median unit.
// Assumes unsigned samples and an odd window size.
package rmu_pkg;

    // Middle rank of a window of n samples
    function automatic int unsigned mid_rank(input int unsigned n);
        return (n - 1) / 2;
    endfunction

endpackage

// File: rtl/rmu_compare_row.sv
// Module: compares an incoming sample with every stored sample of the
// current window in a single cycle. Only the slots below the write
// position take part. Returns a mask of older samples that are larger
// than the newcomer, and the number of them.
// Assumes: the slots below wr_pos hold the samples of the current window.
module rmu_compare_row #(
    parameter int N_SAMPLES = 9,
    parameter int DATA_W    = 8,
    parameter int POS_W     = 4
) (
    input  logic [DATA_W-1:0] new_data,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [DATA_W-1:0] samples [N_SAMPLES],
    output logic [N_SAMPLES-1:0] larger_mask,
    output logic [POS_W-1:0]  larger_cnt
);

    // One comparator per slot, gated by slot occupancy
    for (genvar j = 0; j < N_SAMPLES; j++) begin : g_cmp
        assign larger_mask[j] = (POS_W'(j) < wr_pos) && (new_data < samples[j]);
    end

    // Population count of the larger-than mask
    always_comb begin
        larger_cnt = '0;
        for (int j = 0; j < N_SAMPLES; j++) begin
            larger_cnt = larger_cnt + POS_W'(larger_mask[j]);
        end
    end

endmodule

// File: rtl/rmu_rank_store.sv
// Module: holds the samples and rank counters of one window. A write
// stores the sample in slot wr_pos with rank wr_pos - larger_cnt. In the
// same cycle, every older slot flagged in larger_mask has its rank raised
// by one.
// Assumes: larger_mask only flags slots below wr_pos.
module rmu_rank_store #(
    parameter int N_SAMPLES = 9,
    parameter int DATA_W    = 8,
    parameter int POS_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [POS_W-1:0]     wr_pos,
    input  logic [DATA_W-1:0]    new_data,
    input  logic [N_SAMPLES-1:0] larger_mask,
    input  logic [POS_W-1:0]     larger_cnt,
    output logic [DATA_W-1:0]    samples [N_SAMPLES],
    output logic [POS_W-1:0]     ranks   [N_SAMPLES]
);

    for (genvar j = 0; j < N_SAMPLES; j++) begin : g_slot
        // Per-slot sample and rank update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samples[j] <= '0;
                ranks[j]   <= '0;
            end else if (wr_en && (wr_pos == POS_W'(j))) begin
                samples[j] <= new_data;
                ranks[j]   <= wr_pos - larger_cnt;
            end else if (wr_en && larger_mask[j]) begin
                ranks[j]   <= ranks[j] + 1'b1;
            end
        end

        AST_RANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ranks[j] < POS_W'(N_SAMPLES)); // R4
    end

    AST_NEW_RANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ranks[$past(wr_pos)] <= $past(wr_pos)); // R2

endmodule

// File: rtl/rmu_select.sv
// Module: picks the stored sample whose rank equals the middle rank.
// Because the ranks of a full window are distinct, the OR of the masked
// samples is the single matching sample.
// Assumes: the ranks form a permutation of 0..N-1 whenever the result is used.
module rmu_select #(
    parameter int N_SAMPLES = 9,
    parameter int DATA_W    = 8,
    parameter int POS_W     = 4
) (
    input  logic [DATA_W-1:0] samples [N_SAMPLES],
    input  logic [POS_W-1:0]  ranks   [N_SAMPLES],
    output logic [N_SAMPLES-1:0] hit,
    output logic [DATA_W-1:0] median
);

    localparam int unsigned MID = rmu_pkg::mid_rank(N_SAMPLES);

    for (genvar j = 0; j < N_SAMPLES; j++) begin : g_hit
        assign hit[j] = (ranks[j] == POS_W'(MID));
    end

    // OR-reduce the samples gated by their match bit
    always_comb begin
        median = '0;
        for (int j = 0; j < N_SAMPLES; j++) begin
            median = median | (samples[j] & {DATA_W{hit[j]}});
        end
    end

endmodule

// File: rtl/rank_median_unit.sv
// Module: streaming median of N samples, using one rank counter per
// stored sample. It tracks the write position, applies the start marker,
// and raises the result pulse one cycle after the last sample.
// Assumes: N_SAMPLES is odd and at least 3; samples are unsigned.
module rank_median_unit #(
    parameter int N_SAMPLES = 9,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_median
);

    localparam int POS_W = $clog2(N_SAMPLES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_SAMPLES - 1);

    logic [POS_W-1:0]     pos_q;
    logic [POS_W-1:0]     wr_pos;
    logic [DATA_W-1:0]    samples [N_SAMPLES];
    logic [POS_W-1:0]     ranks   [N_SAMPLES];
    logic [N_SAMPLES-1:0] larger_mask;
    logic [POS_W-1:0]     larger_cnt;
    logic [N_SAMPLES-1:0] hit;
    logic                 done_q;

    // Start marker forces the write position back to slot 0
    assign wr_pos = in_first ? '0 : pos_q;

    // Write position: advance per accepted sample, wrap after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (in_valid) begin
            pos_q <= (wr_pos == LAST_POS) ? '0 : wr_pos + 1'b1;
        end
    end

    // Result pulse: the cycle after the last slot is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= in_valid && (wr_pos == LAST_POS);
        end
    end

    rmu_compare_row #(
        .N_SAMPLES(N_SAMPLES), .DATA_W(DATA_W), .POS_W(POS_W)
    ) u_cmp (
        .new_data   (in_data),
        .wr_pos     (wr_pos),
        .samples    (samples),
        .larger_mask(larger_mask),
        .larger_cnt (larger_cnt)
    );

    rmu_rank_store #(
        .N_SAMPLES(N_SAMPLES), .DATA_W(DATA_W), .POS_W(POS_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (in_valid),
        .wr_pos     (wr_pos),
        .new_data   (in_data),
        .larger_mask(larger_mask),
        .larger_cnt (larger_cnt),
        .samples    (samples),
        .ranks      (ranks)
    );

    rmu_select #(
        .N_SAMPLES(N_SAMPLES), .DATA_W(DATA_W), .POS_W(POS_W)
    ) u_sel (
        .samples(samples),
        .ranks  (ranks),
        .hit    (hit),
        .median (out_median)
    );

    assign out_valid = done_q;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(hit) == 1); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R6
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pos_q)); // R9

endmodule

// File: tb/rank_median_unit_bench.sv
module rank_median_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v9 = 0, f9 = 0, v25 = 0, f25 = 0;
    logic [7:0] d9 = 0, d25 = 0;
    logic ov9, ov25;
    logic [7:0] om9, om25;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rank_median_unit #(.N_SAMPLES(9), .DATA_W(8)) u_rank_median_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(v9), .in_first(f9), .in_data(d9),
        .out_valid(ov9), .out_median(om9));

    rank_median_unit #(.N_SAMPLES(25), .DATA_W(8)) u_rank_median_unit_25 (
        .clk(clk), .rst_n(rst_n), .in_valid(v25), .in_first(f25), .in_data(d25),
        .out_valid(ov25), .out_median(om25));

    function automatic int sorted_mid(input int s[$]);
        int q[$];
        q = s;
        q.sort();
        return q[(q.size() - 1) / 2];
    endfunction

    task automatic drive(input int w, input bit v, input bit f, input int d);
        if (w == 9) begin v9 = v; f9 = f; d9 = 8'(d); end
        else begin v25 = v; f25 = f; d25 = 8'(d); end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int obs_v(input int w);
        return (w == 9) ? int'(ov9) : int'(ov25);
    endfunction

    function automatic int obs_m(input int w);
        return (w == 9) ? int'(om9) : int'(om25);
    endfunction

    // Feed a window; optionally check the pulse of the previous window at the first edge
    task automatic feed(input int w, input int s[$], input bit mark, input int gap,
                        input int prev_exp, input string req);
        for (int k = 0; k < s.size(); k++) begin
            if (k > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    drive(w, 0, g[0], int'($urandom_range(255)));
                end
            end
            @(negedge clk);
            if (k == 0 && prev_exp >= 0) begin
                check({req, " valid"}, obs_v(w), 1);
                check({req, " median"}, obs_m(w), prev_exp);
            end
            drive(w, 1, mark && k == 0, s[k]);
        end
    endtask

    // Idle after a window, check the pulse and that it lasts one cycle
    task automatic finish(input int w, input int exp, input string req);
        @(negedge clk);
        drive(w, 0, 0, 0);
        check({req, " valid"}, obs_v(w), 1);
        check({req, " median"}, obs_m(w), exp);
        @(negedge clk);
        check("R6 pulse width", obs_v(w), 0);
    endtask

    function automatic void rand_win(input int n, input int span, ref int s[$]);
        s = {};
        for (int k = 0; k < n; k++) s.push_back(int'($urandom_range(span)));
    endfunction

    initial begin
        int a[$];
        int b[$];
        void'($urandom(32'h5EED_0123));
        repeat (3) @(negedge clk);
        check("R1 reset valid 9", int'(ov9), 0);
        check("R1 reset valid 25", int'(ov25), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid after reset", int'(ov9), 0);

        // R4 mixed example, R2/R3 ties ranked by arrival
        a = '{20, 42, 31, 16, 75, 50, 10, 90, 31};
        feed(9, a, 1, 0, -1, "R4");
        finish(9, 31, "R4 example");

        a = '{1, 2, 3, 4, 5, 6, 7, 8, 9};
        feed(9, a, 1, 0, -1, "R2");
        finish(9, 5, "R2 ascending");

        a = '{250, 200, 150, 100, 90, 80, 70, 60, 0};
        feed(9, a, 1, 0, -1, "R3");
        finish(9, 90, "R3 descending");

        a = '{77, 77, 77, 77, 77, 77, 77, 77, 77};
        feed(9, a, 1, 0, -1, "R10");
        finish(9, 77, "R10 all equal");

        // R7: partial window discarded by a new start marker
        a = '{255, 255, 255, 255};
        feed(9, a, 1, 0, -1, "R7");
        b = '{3, 9, 1, 8, 2, 7, 4, 6, 5};
        feed(9, b, 1, 0, -1, "R7");
        finish(9, 5, "R7 restart");

        // R9: idle cycles with junk data inside a window
        a = '{40, 10, 30, 60, 20, 90, 80, 70, 50};
        feed(9, a, 1, 3, -1, "R9");
        finish(9, 50, "R9 gaps");

        // R8: back to back, second window without marker, then with marker
        a = '{9, 8, 7, 6, 5, 4, 3, 2, 1};
        b = '{100, 0, 100, 0, 100, 0, 100, 0, 100};
        feed(9, a, 1, 0, -1, "R8");
        feed(9, b, 0, 0, 5, "R8 wrap prev");
        feed(9, a, 1, 0, 100, "R8 marked prev");
        finish(9, 5, "R8 last");

        // R5/R10 random windows, narrow range forces ties
        for (int r = 0; r < 40; r++) begin
            rand_win(9, (r % 2) ? 255 : 7, a);
            feed(9, a, 1, r % 3, -1, "R5");
            finish(9, sorted_mid(a), "R5 random 9");
        end
        for (int r = 0; r < 30; r++) begin
            rand_win(25, (r % 2) ? 255 : 3, a);
            feed(25, a, 1, 0, -1, "R5");
            finish(25, sorted_mid(a), "R5 random 25");
        end
        b = {};
        for (int k = 0; k < 25; k++) b.push_back(k * 10);
        feed(25, b, 1, 0, -1, "R2");
        finish(25, 120, "R2 ascending 25");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule